// File: doc/BRIEF.md
# Video control signal conditioner

This block runs in the pixel-clock domain. It takes three video control lines: data enable, horizontal sync and vertical sync. It limits how often each line may change level, so that a serial link that spends 28 bit times per pixel can carry every change. Each output is registered. When its limits allow, a change on an input reaches the output at the clock edge that samples it. When a change would break a limit, it is held back. The output keeps its old level until the change becomes legal.

A glitch qualifier can be switched on for data enable and horizontal sync. When it is on, a new level must be seen on three consecutive clock edges before it counts. Shorter pulses are removed. The switch is the OR of a configuration pin and a register bit. Vertical sync is never qualified for width, but it carries its own long minimum pulse width. A sticky flag per line records every suppressed or deferred change. Software clears a flag by writing a one to it.

Top module: `vcf_ctrl_filter`

## Requirements
- R1: While `rst_n` is low, all three outputs and all three flags are low. Reset also empties every change history, so after reset the first change on any line is applied without delay.
- R2: `de_o` and `hs_o` each change level at most 2 times in any 130 consecutive clock edges. A change that would be the third is held back. The output keeps its old level and takes the new one at the first edge that lies 130 edges after the oldest of the two earlier changes.
- R3: Once `vs_o` changes, it keeps its level for at least 130 edges, so it changes at most once in any 130 consecutive edges. An earlier request is deferred. It is applied exactly 130 edges after the previous `vs_o` change.
- R4: The glitch qualifier is active when `cfg_filt_en` or `reg_filt_en` is high. Either input alone enables it.
- R5: With the qualifier active, a new `de_i` or `hs_i` level reaches the output only after it has been sampled on 3 consecutive edges. The output changes at the third edge. A level that is sampled on 1 or 2 edges and then goes away never appears on the output.
- R6: With the qualifier inactive, `de_i` and `hs_i` reach their outputs one edge after they are sampled, for any pulse width, including a one-cycle pulse. The limit in R2 still applies.
- R7: `vs_i` is never qualified for width. When R3 allows, it reaches `vs_o` one edge after it is sampled, whatever the state of the qualifier.
- R8: The flag vector `viol` has bit 0 for data enable, bit 1 for horizontal sync and bit 2 for vertical sync. A bit is set when a qualified-away pulse ends, and in every cycle in which a wanted output change is held back. It then stays set until it is cleared.
- R9: A high bit in `viol_clr` clears the matching flag at the next edge. If a set event occurs in the same cycle as the clear, the set wins and the flag stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset. Its release is synchronized inside the block. |
| cfg_filt_en | input | 1 | Glitch qualifier enable from a configuration pin |
| reg_filt_en | input | 1 | Glitch qualifier enable from a register bit |
| de_i | input | 1 | Data enable in |
| hs_i | input | 1 | Horizontal sync in |
| vs_i | input | 1 | Vertical sync in |
| viol_clr | input | 3 | Write-one-to-clear strobes for the flags (bit 0 DE, bit 1 HS, bit 2 VS) |
| de_o | output | 1 | Conditioned data enable |
| hs_o | output | 1 | Conditioned horizontal sync |
| vs_o | output | 1 | Conditioned vertical sync |
| viol | output | 3 | Sticky suppression/deferral flags (bit 0 DE, bit 1 HS, bit 2 VS) |

## Verification
The bench places a third data-enable change exactly 129 and exactly 130 edges after the oldest change in the window. A window that is off by one, or a history that records its timestamps one cycle late, moves that edge. Vertical sync is tested the same way around its 130-edge minimum. Qualified pulses of exactly 2 and exactly 3 samples are applied to show whether the qualifier is too strict or too lenient. A one-cycle pulse with the qualifier off shows whether the qualifier leaks into the unfiltered mode. A clear strobe is issued while a deferral is still in progress; a flag that lets the clear win would drop to zero.

// File: rtl/vcf_pkg.sv
package vcf_pkg;
  localparam int NUM_CH = 3;
  localparam int CH_DE  = 0;
  localparam int CH_HS  = 1;
  localparam int CH_VS  = 2;

  typedef logic [NUM_CH-1:0] ch_vec_t;
endpackage

// File: rtl/vcf_glitch.sv
// Level qualifier: a new level is accepted on the MIN_RUN-th consecutive sample.
module vcf_glitch #(
  parameter int MIN_RUN = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic filt_on,
  input  logic din,
  output logic lvl,
  output logic drop
);
  localparam int RW = $clog2(MIN_RUN + 1);
  localparam logic [RW-1:0] RUN_MAX = RW'(MIN_RUN);

  logic          cand_q, cand_d;
  logic          keep_q, keep_d;
  logic [RW-1:0] run_q, run_d;
  logic          same, qual;

  always_comb begin
    same = (din == cand_q);
    if (!same) begin
      run_d = RW'(1);
    end else if (run_q == RUN_MAX) begin
      run_d = run_q;
    end else begin
      run_d = run_q + RW'(1);
    end
    qual   = !filt_on || (run_d >= RUN_MAX);
    keep_d = qual ? din : keep_q;
    cand_d = din;
    // a run that never qualified has just ended
    drop   = filt_on && !same && (cand_q != keep_q);
    lvl    = keep_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cand_q <= 1'b0;
      keep_q <= 1'b0;
      run_q  <= '0;
    end else begin
      cand_q <= cand_d;
      keep_q <= keep_d;
      run_q  <= run_d;
    end
  end
endmodule

// File: rtl/vcf_budget.sv
// Sliding-window change limiter with a minimum hold time between changes.
module vcf_budget #(
  parameter int WINDOW   = 130,
  parameter int BUDGET   = 2,
  parameter int MIN_HOLD = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic want_lvl,
  output logic out_lvl,
  output logic held
);
  localparam int AW = $clog2(WINDOW + 1);
  localparam int HW = $clog2(MIN_HOLD + 1);
  localparam logic [AW-1:0] AGE_MAX  = AW'(WINDOW);
  localparam logic [HW-1:0] HOLD_MAX = HW'(MIN_HOLD);

  logic [AW-1:0] age_q   [BUDGET];
  logic [AW-1:0] age_inc [BUDGET];
  logic [AW-1:0] age_d   [BUDGET];
  logic [HW-1:0] hold_q, hold_d;
  logic          out_q, out_d;
  logic          room, change, differ;

  always_comb begin
    for (int i = 0; i < BUDGET; i++) begin
      age_inc[i] = (age_q[i] == AGE_MAX) ? age_q[i] : age_q[i] + AW'(1);
    end
    differ = (want_lvl != out_q);
    room   = (age_q[BUDGET-1] >= AGE_MAX) && (hold_q >= HOLD_MAX);
    change = differ && room;
    held   = differ && !room;
    out_d  = change ? want_lvl : out_q;
    if (change) begin
      age_d[0] = AW'(1);
      for (int i = 1; i < BUDGET; i++) begin
        age_d[i] = age_inc[i-1];
      end
      hold_d = HW'(1);
    end else begin
      for (int i = 0; i < BUDGET; i++) begin
        age_d[i] = age_inc[i];
      end
      hold_d = (hold_q == HOLD_MAX) ? hold_q : hold_q + HW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < BUDGET; i++) begin
        age_q[i] <= AGE_MAX;
      end
      hold_q <= HOLD_MAX;
      out_q  <= 1'b0;
    end else begin
      for (int i = 0; i < BUDGET; i++) begin
        age_q[i] <= age_d[i];
      end
      hold_q <= hold_d;
      out_q  <= out_d;
    end
  end

  assign out_lvl = out_q;
endmodule

// File: rtl/vcf_chan.sv
// One control line: optional qualifier, change limiter, sticky flag.
module vcf_chan #(
  parameter int USE_GLITCH = 1,
  parameter int MIN_RUN    = 3,
  parameter int WINDOW     = 130,
  parameter int BUDGET     = 2,
  parameter int MIN_HOLD   = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic filt_on,
  input  logic din,
  input  logic flag_clr,
  output logic dout,
  output logic flag
);
  logic lvl, drop, held;
  logic flag_q, flag_d;

  if (USE_GLITCH != 0) begin : g_filt
    vcf_glitch #(.MIN_RUN(MIN_RUN)) u_glitch (
      .clk     (clk),
      .rst_n   (rst_n),
      .filt_on (filt_on),
      .din     (din),
      .lvl     (lvl),
      .drop    (drop)
    );
  end else begin : g_pass
    logic unused_filt;
    assign unused_filt = filt_on;
    assign lvl  = din;
    assign drop = 1'b0;
  end

  vcf_budget #(.WINDOW(WINDOW), .BUDGET(BUDGET), .MIN_HOLD(MIN_HOLD)) u_budget (
    .clk      (clk),
    .rst_n    (rst_n),
    .want_lvl (lvl),
    .out_lvl  (dout),
    .held     (held)
  );

  always_comb begin
    if (drop || held) begin
      flag_d = 1'b1;
    end else if (flag_clr) begin
      flag_d = 1'b0;
    end else begin
      flag_d = flag_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
    end else begin
      flag_q <= flag_d;
    end
  end

  assign flag = flag_q;
endmodule

// File: rtl/vcf_ctrl_filter.sv
module vcf_ctrl_filter
  import vcf_pkg::*;
#(
  parameter int WINDOW      = 130,
  parameter int DEHS_BUDGET = 2,
  parameter int VS_BUDGET   = 1,
  parameter int VS_MIN_W    = 130,
  parameter int MIN_RUN     = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cfg_filt_en,
  input  logic       reg_filt_en,
  input  logic       de_i,
  input  logic       hs_i,
  input  logic       vs_i,
  input  logic [2:0] viol_clr,
  output logic       de_o,
  output logic       hs_o,
  output logic       vs_o,
  output logic [2:0] viol
);
  logic [1:0] rst_sync_q, rst_sync_d;
  logic       core_rst_n;
  logic       filt_on;
  ch_vec_t    din_v, dout_v, flag_v;

  assign rst_sync_d = {rst_sync_q[0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= rst_sync_d;
    end
  end

  assign core_rst_n = rst_sync_q[1];
  assign filt_on    = cfg_filt_en | reg_filt_en;

  always_comb begin
    din_v        = '0;
    din_v[CH_DE] = de_i;
    din_v[CH_HS] = hs_i;
    din_v[CH_VS] = vs_i;
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    if (c == CH_VS) begin : g_vs
      vcf_chan #(
        .USE_GLITCH (0),
        .MIN_RUN    (MIN_RUN),
        .WINDOW     (WINDOW),
        .BUDGET     (VS_BUDGET),
        .MIN_HOLD   (VS_MIN_W)
      ) u_chan (
        .clk      (clk),
        .rst_n    (core_rst_n),
        .filt_on  (filt_on),
        .din      (din_v[c]),
        .flag_clr (viol_clr[c]),
        .dout     (dout_v[c]),
        .flag     (flag_v[c])
      );
    end else begin : g_dh
      vcf_chan #(
        .USE_GLITCH (1),
        .MIN_RUN    (MIN_RUN),
        .WINDOW     (WINDOW),
        .BUDGET     (DEHS_BUDGET),
        .MIN_HOLD   (1)
      ) u_chan (
        .clk      (clk),
        .rst_n    (core_rst_n),
        .filt_on  (filt_on),
        .din      (din_v[c]),
        .flag_clr (viol_clr[c]),
        .dout     (dout_v[c]),
        .flag     (flag_v[c])
      );
    end
  end

  assign de_o = dout_v[CH_DE];
  assign hs_o = dout_v[CH_HS];
  assign vs_o = dout_v[CH_VS];
  assign viol = flag_v;
endmodule

// File: rtl/vcf_ctrl_filter_chk.sv
module vcf_ctrl_filter_chk #(
  parameter int WINDOW      = 130,
  parameter int DEHS_BUDGET = 2,
  parameter int VS_MIN_W    = 130
) (
  input logic       clk,
  input logic       rst_n,
  input logic [2:0] viol_clr,
  input logic       de_o,
  input logic       hs_o,
  input logic       vs_o,
  input logic [2:0] viol
);
  localparam int AW = $clog2(WINDOW + 1);
  localparam int VW = $clog2(VS_MIN_W + 1);
  localparam logic [AW-1:0] AMAX = AW'(WINDOW);
  localparam logic [VW-1:0] VMAX = VW'(VS_MIN_W);

  logic          de_prev, hs_prev, vs_prev;
  logic          de_chg, hs_chg, vs_chg;
  logic [AW-1:0] de_age [DEHS_BUDGET];
  logic [AW-1:0] hs_age [DEHS_BUDGET];
  logic [VW-1:0] vs_run;

  assign de_chg = (de_o != de_prev);
  assign hs_chg = (hs_o != hs_prev);
  assign vs_chg = (vs_o != vs_prev);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      de_prev <= 1'b0;
      hs_prev <= 1'b0;
      vs_prev <= 1'b0;
      vs_run  <= VMAX;
      for (int i = 0; i < DEHS_BUDGET; i++) begin
        de_age[i] <= AMAX;
        hs_age[i] <= AMAX;
      end
    end else begin
      de_prev <= de_o;
      hs_prev <= hs_o;
      vs_prev <= vs_o;
      vs_run  <= vs_chg ? VW'(1) : ((vs_run == VMAX) ? vs_run : vs_run + VW'(1));
      for (int i = 0; i < DEHS_BUDGET; i++) begin
        if (de_chg) begin
          if (i == 0) de_age[i] <= AW'(1);
          else de_age[i] <= (de_age[(i>0)?i-1:0] == AMAX) ? AMAX : de_age[(i>0)?i-1:0] + AW'(1);
        end else begin
          de_age[i] <= (de_age[i] == AMAX) ? AMAX : de_age[i] + AW'(1);
        end
        if (hs_chg) begin
          if (i == 0) hs_age[i] <= AW'(1);
          else hs_age[i] <= (hs_age[(i>0)?i-1:0] == AMAX) ? AMAX : hs_age[(i>0)?i-1:0] + AW'(1);
        end else begin
          hs_age[i] <= (hs_age[i] == AMAX) ? AMAX : hs_age[i] + AW'(1);
        end
      end
    end
  end

  AST_DE_CHANGE_BUDGET: assert property (@(posedge clk) disable iff (!rst_n)
    de_chg |-> (de_age[DEHS_BUDGET-1] >= AMAX)) else $error("de_o over budget"); // R2

  AST_HS_CHANGE_BUDGET: assert property (@(posedge clk) disable iff (!rst_n)
    hs_chg |-> (hs_age[DEHS_BUDGET-1] >= AMAX)) else $error("hs_o over budget"); // R2

  AST_VS_MIN_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
    vs_chg |-> (vs_run >= VMAX)) else $error("vs_o pulse too short"); // R3

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    ((viol & ~viol_clr) != 3'b000) |=> (((($past(viol) & ~$past(viol_clr))) & ~viol) == 3'b000))
    else $error("flag dropped without clear"); // R8

  always @(posedge clk) begin
    if (!rst_n) begin
      AST_RESET_QUIET: assert ({de_o, hs_o, vs_o, viol} == 6'b0) else $error("outputs active in reset"); // R1
    end
  end
endmodule

bind vcf_ctrl_filter vcf_ctrl_filter_chk #(
  .WINDOW      (WINDOW),
  .DEHS_BUDGET (DEHS_BUDGET),
  .VS_MIN_W    (VS_MIN_W)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .viol_clr (viol_clr),
  .de_o     (de_o),
  .hs_o     (hs_o),
  .vs_o     (vs_o),
  .viol     (viol)
);

// File: tb/sim_vcf_ctrl_filter.sv
module sim_vcf_ctrl_filter;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       cfg_filt_en, reg_filt_en;
  logic       de_i, hs_i, vs_i;
  logic [2:0] viol_clr;
  logic       de_o, hs_o, vs_o;
  logic [2:0] viol;

  int checks = 0;
  int fails  = 0;
  bit ended  = 1'b0;

  always #2 clk = ~clk;

  vcf_ctrl_filter u0 (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_filt_en (cfg_filt_en),
    .reg_filt_en (reg_filt_en),
    .de_i        (de_i),
    .hs_i        (hs_i),
    .vs_i        (vs_i),
    .viol_clr    (viol_clr),
    .de_o        (de_o),
    .hs_o        (hs_o),
    .vs_o        (vs_o),
    .viol        (viol)
  );

  // en, de, hs, vs, edges to apply, expected {vs,hs,de}, expected viol
  typedef struct packed {
    logic       en;
    logic       de;
    logic       hs;
    logic       vs;
    logic [8:0] cyc;
    logic [2:0] exp_o;
    logic [2:0] exp_v;
  } vec_t;

  localparam int NVEC = 15;
  localparam vec_t VEC [NVEC] = '{
    '{1'b0, 1'b1, 1'b0, 1'b0, 9'd1,   3'b001, 3'b000}, // R6 de passes
    '{1'b0, 1'b0, 1'b1, 1'b0, 9'd1,   3'b010, 3'b000}, // R6 1-cycle pulse
    '{1'b0, 1'b1, 1'b1, 1'b0, 9'd1,   3'b010, 3'b001}, // R2 third de change held
    '{1'b0, 1'b1, 1'b0, 1'b0, 9'd1,   3'b000, 3'b001}, // R2
    '{1'b0, 1'b0, 1'b1, 1'b1, 9'd1,   3'b100, 3'b011}, // R2 hs held, R7 vs passes
    '{1'b0, 1'b0, 1'b0, 1'b0, 9'd1,   3'b100, 3'b111}, // R3 vs deferred
    '{1'b0, 1'b0, 1'b0, 1'b0, 9'd140, 3'b000, 3'b111}, // R3 vs applied later
    '{1'b1, 1'b1, 1'b0, 1'b0, 9'd2,   3'b000, 3'b111}, // R5 two samples
    '{1'b1, 1'b0, 1'b0, 1'b0, 9'd1,   3'b000, 3'b111}, // R5 pulse removed
    '{1'b1, 1'b1, 1'b0, 1'b0, 9'd3,   3'b001, 3'b111}, // R5 three samples
    '{1'b1, 1'b1, 1'b1, 1'b0, 9'd2,   3'b001, 3'b111}, // R5
    '{1'b1, 1'b1, 1'b1, 1'b0, 9'd1,   3'b011, 3'b111}, // R5
    '{1'b1, 1'b0, 1'b1, 1'b1, 9'd3,   3'b010, 3'b111}, // R5 de falls, R3 vs held
    '{1'b1, 1'b1, 1'b1, 1'b1, 9'd3,   3'b010, 3'b111}, // R2 de held under filter
    '{1'b1, 1'b1, 1'b1, 1'b1, 9'd130, 3'b111, 3'b111}  // R2 R3 both released
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    de_i = 1'b0; hs_i = 1'b0; vs_i = 1'b0;
    cfg_filt_en = 1'b0; reg_filt_en = 1'b0; viol_clr = 3'b000;
    step(2);
    check("R1 outputs in reset", {29'd0, vs_o, hs_o, de_o}, 32'd0);
    check("R1 flags in reset", {29'd0, viol}, 32'd0);
    rst_n = 1'b1;
    step(4);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog actual=running expected=done");
    finish_run();
  end

  initial begin
    rst_n = 1'b1;
    de_i = 1'b0; hs_i = 1'b0; vs_i = 1'b0;
    cfg_filt_en = 1'b0; reg_filt_en = 1'b0; viol_clr = 3'b000;
    #1;
    do_reset();

    // vector table
    for (int i = 0; i < NVEC; i++) begin
      cfg_filt_en = VEC[i].en;
      de_i = VEC[i].de;
      hs_i = VEC[i].hs;
      vs_i = VEC[i].vs;
      step(int'(VEC[i].cyc));
      check($sformatf("R2/R3/R5/R6/R7 row %0d outputs", i), {29'd0, vs_o, hs_o, de_o}, {29'd0, VEC[i].exp_o});
      check($sformatf("R8 row %0d flags", i), {29'd0, viol}, {29'd0, VEC[i].exp_v});
    end

    // R9 selective clear
    viol_clr = 3'b001; step(1); viol_clr = 3'b000;
    check("R9 clear bit0 only", {29'd0, viol}, 32'd6);
    viol_clr = 3'b110; step(1); viol_clr = 3'b000;
    check("R9 clear bits 1 and 2", {29'd0, viol}, 32'd0);

    // R1 reset mid-run, history cleared
    do_reset();

    // R4 register enable, R5 two-sample pulse removed, three-sample passes
    reg_filt_en = 1'b1;
    hs_i = 1'b1; step(2);
    check("R4 R5 hs after two samples", {31'd0, hs_o}, 32'd0);
    hs_i = 1'b0; step(1);
    check("R5 hs pulse removed", {31'd0, hs_o}, 32'd0);
    check("R8 hs suppression flagged", {29'd0, viol}, 32'd2);
    hs_i = 1'b1; step(2);
    check("R5 hs after two samples again", {31'd0, hs_o}, 32'd0);
    step(1);
    check("R5 hs after third sample", {31'd0, hs_o}, 32'd1);

    // R4 pin enable alone
    reg_filt_en = 1'b0; cfg_filt_en = 1'b1;
    de_i = 1'b1; step(2);
    de_i = 1'b0; step(1);
    check("R4 de pulse removed via pin enable", {31'd0, de_o}, 32'd0);

    // R6 unfiltered one-cycle pulse, then R2 boundary
    cfg_filt_en = 1'b0;
    viol_clr = 3'b111; step(1); viol_clr = 3'b000;
    check("R9 clear all", {29'd0, viol}, 32'd0);
    de_i = 1'b1; step(1);
    check("R6 de one-cycle latency", {31'd0, de_o}, 32'd1);
    de_i = 1'b0; step(1);
    check("R6 de one-cycle pulse ends", {31'd0, de_o}, 32'd0);
    check("R6 no flag for short pulse", {29'd0, viol}, 32'd0);
    de_i = 1'b1; step(128);
    check("R2 de held at edge 129", {31'd0, de_o}, 32'd0);
    check("R8 de deferral flagged", {29'd0, viol}, 32'd1);
    step(1);
    check("R2 de applied at edge 130", {31'd0, de_o}, 32'd1);

    // R7 vs passes with qualifier on, R3 boundary, R9 set wins
    cfg_filt_en = 1'b1;
    viol_clr = 3'b001; step(1); viol_clr = 3'b000;
    vs_i = 1'b1; step(1);
    check("R7 vs one-cycle latency with filter on", {31'd0, vs_o}, 32'd1);
    vs_i = 1'b0; step(64);
    viol_clr = 3'b100; step(1); viol_clr = 3'b000;
    check("R9 set wins over clear", {29'd0, viol}, 32'd4);
    step(64);
    check("R3 vs held at edge 129", {31'd0, vs_o}, 32'd1);
    step(1);
    check("R3 vs applied at edge 130", {31'd0, vs_o}, 32'd0);

    finish_run();
  end
endmodule